// File: doc/BRIEF.md
# PWM Double-Buffered Reload Controller

This block sits between a register bus and a set of PWM submodules. It controls when new timing parameters reach them. For each submodule, software writes a prescaler code, an initial count, a fractional trim and several compare values into staging registers. It then arms a per-submodule load-okay flag. The staged set is copied into the active set as one unit. This happens either on the next reload pulse from that submodule or, when its load-mode bit is set, in the cycle after arming. The counter, the comparators and the outputs therefore never see a half-written parameter set.

A small state machine per submodule has two states. In `LD_IDLE` the staging registers are open. `LD_ARMED` means load-okay is set and the staging registers are locked. The machine has three transitions. *arm* goes from `LD_IDLE` to `LD_ARMED` when a 1 is written to the flag and no clear strobe comes with it. *commit* goes from `LD_ARMED` to `LD_IDLE` when the trigger fires and there is no clear strobe; the active set is loaded and `commit_pulse` is high for that cycle. *cancel* goes from `LD_ARMED` to `LD_IDLE` on a clear strobe; it wins over a reload in the same cycle.

The block also holds the following, shared across submodules:
- the run bits, which drive the per-submodule generator enable;
- an auxiliary-clock option through which submodules 1 and up follow submodule 0's run bit;
- a buffered polarity-source select bit per submodule, which reaches its active copy only on that submodule's force pulse.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset every active and staged value is 0, every load-okay, run, polarity buffer and active polarity bit is 0, and a read of the master word (address 0) returns 0.
- R2: The master word at address 0 holds load-okay for submodule i at bit i, the clear strobe at bit 4+i, run at bit 8+i and the polarity buffer at bit 12+i. Writing 1 to bit i sets load-okay. Writing 0 there leaves it unchanged. Reads are registered and appear the cycle after `rd_en`.
- R3: Writing 1 to master bit 4+i clears load-okay i. These strobe bits always read back as 0.
- R4: When load-okay is set and a clear strobe and a reload pulse arrive in the same cycle, no value is copied and load-okay ends up 0.
- R5: When load-mode is 0 and load-okay is set, the staged set is copied to the active outputs at the clock edge that ends a cycle with the reload pulse high. Active values change at no other time except by R6.
- R6: When load-mode is 1 (address 4, bit 0, for the paged submodule), a set load-okay commits at the end of the first cycle it is seen, with no reload pulse needed.
- R7: Writes to staged prescaler (addr 2), initial count (3), fractional (5) and compare registers (6 and 7) of the submodule chosen by the page register (addr 1) are ignored while its load-okay is set.
- R8: Load-okay clears at the commit. `commit_pulse[i]` is high for exactly the commit cycle.
- R9: `gen_en[i]` follows run bit i. When it is 0 the submodule counter is held reset.
- R10: For submodules 1 and up, when `clk_sel_aux[i]` is 1, `gen_en[i]` follows run bit 0 and the local run bit is ignored.
- R11: A write to polarity bit 12+i changes only the buffer, which reads back. `pol_active[i]` takes the buffered value at the end of a cycle with `force_evt[i]` high and is otherwise held.
- R12: A reload, force or commit on one submodule leaves the other submodules' state and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | BUS_W | Write data |
| rd_data | output | BUS_W | Registered read data |
| reload_evt | input | NUM_SM | Per-submodule reload pulse |
| force_evt | input | NUM_SM | Per-submodule force-output pulse |
| clk_sel_aux | input | NUM_SM | Submodule uses submodule 0's clock (bit 0 unused) |
| commit_pulse | output | NUM_SM | Staged set committed this cycle |
| gen_en | output | NUM_SM | Effective generator enable, counter reset when 0 |
| pol_active | output | NUM_SM | Active polarity-source select |
| act_prsc | output | NUM_SM*PRSC_W | Active prescaler codes |
| act_init | output | NUM_SM*DATA_W | Active initial counts |
| act_frac | output | NUM_SM*FRAC_W | Active fractional trims |
| act_val | output | NUM_SM*NUM_VAL*DATA_W | Active compare values |

## Verification
Directed sequences separate the three exits from the armed state:
- a reload pulse on a different submodule, which must not commit;
- a reload on the armed submodule, which must commit;
- a reload that comes with a clear strobe, which must cancel;
- load-mode 1 with no reload at all, which must still commit.

Writes of 0 to the flag and writes to locked staging registers show whether the lock and set-only behaviour hold. Constrained random traffic then mixes writes to every address, sparse clear strobes, overlapping reload and force pulses and changing clock selects. A bench model predicts every output each cycle, so ordering faults that the directed cases cannot reach become visible.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;

    localparam logic [ADDR_W-1:0] A_MCTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_PAGE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_PRSC  = 4'd2;
    localparam logic [ADDR_W-1:0] A_INIT  = 4'd3;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'd4;
    localparam logic [ADDR_W-1:0] A_FRAC  = 4'd5;
    localparam logic [ADDR_W-1:0] A_VAL0  = 4'd6;
endpackage

// File: rtl/pwm_sm_loader.sv
module pwm_sm_loader
    import pwm_reload_pkg::*;
#(
    parameter int BUS_W   = 16,
    parameter int DATA_W  = 16,
    parameter int PRSC_W  = 3,
    parameter int FRAC_W  = 5,
    parameter int NUM_VAL = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      set_req,
    input  logic                      clr_req,
    input  logic                      stg_we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [BUS_W-1:0]          wdata,
    input  logic                      reload_evt,
    output logic                      ldok,
    output logic                      commit,
    output logic                      mode_q,
    output logic [PRSC_W-1:0]         stg_prsc,
    output logic [DATA_W-1:0]         stg_init,
    output logic [FRAC_W-1:0]         stg_frac,
    output logic [NUM_VAL*DATA_W-1:0] stg_val,
    output logic [PRSC_W-1:0]         act_prsc,
    output logic [DATA_W-1:0]         act_init,
    output logic [FRAC_W-1:0]         act_frac,
    output logic [NUM_VAL*DATA_W-1:0] act_val
);
    ld_state_e state_q, state_d;
    logic      fire;
    logic      stg_open;

    assign fire = mode_q || reload_evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm, commit, cancel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (set_req && !clr_req) state_d = LD_ARMED;
            LD_ARMED: if (clr_req || fire)     state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        ldok   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            LD_IDLE:  ;
            LD_ARMED: begin
                ldok   = 1'b1;
                commit = fire && !clr_req;
            end
            default:  ;
        endcase
    end

    assign stg_open = stg_we && (state_q == LD_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            stg_prsc <= '0;
            stg_init <= '0;
            stg_frac <= '0;
        end else begin
            if (stg_we && addr == A_MODE) mode_q <= wdata[0];
            if (stg_open && addr == A_PRSC) stg_prsc <= wdata[PRSC_W-1:0];
            if (stg_open && addr == A_INIT) stg_init <= wdata[DATA_W-1:0];
            if (stg_open && addr == A_FRAC) stg_frac <= wdata[FRAC_W-1:0];
        end
    end

    for (genvar v = 0; v < NUM_VAL; v++) begin : g_val
        localparam logic [ADDR_W-1:0] VADDR = ADDR_W'(int'(A_VAL0) + v);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          stg_val[v*DATA_W +: DATA_W] <= '0;
            else if (stg_open && addr == VADDR)  stg_val[v*DATA_W +: DATA_W] <= wdata[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_prsc <= '0;
            act_init <= '0;
            act_frac <= '0;
            act_val  <= '0;
        end else if (commit) begin
            act_prsc <= stg_prsc;
            act_init <= stg_init;
            act_frac <= stg_frac;
            act_val  <= stg_val;
        end
    end

    assert_clr_cancels_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_ARMED && clr_req) |=> (state_q == LD_IDLE && $stable(act_init)
            && $stable(act_val) && $stable(act_prsc) && $stable(act_frac)));
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_init) && $stable(act_val) && $stable(act_prsc) && $stable(act_frac)));
    assert_stage_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_ARMED) |=> ($stable(stg_init) && $stable(stg_val)
            && $stable(stg_prsc) && $stable(stg_frac)));
    assert_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!ldok && !commit));
    assert_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ldok && mode_q && !clr_req) |-> commit);
endmodule

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
    import pwm_reload_pkg::*;
#(
    parameter int NUM_SM  = 4,
    parameter int BUS_W   = 16,
    parameter int DATA_W  = 16,
    parameter int PRSC_W  = 3,
    parameter int FRAC_W  = 5,
    parameter int NUM_VAL = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [BUS_W-1:0]                 wdata,
    input  logic [NUM_SM-1:0]                ldok,
    input  logic [NUM_SM-1:0]                run_q,
    input  logic [NUM_SM-1:0]                ipol_buf,
    input  logic [NUM_SM-1:0]                mode_all,
    input  logic [NUM_SM*PRSC_W-1:0]         stg_prsc_all,
    input  logic [NUM_SM*DATA_W-1:0]         stg_init_all,
    input  logic [NUM_SM*FRAC_W-1:0]         stg_frac_all,
    input  logic [NUM_SM*NUM_VAL*DATA_W-1:0] stg_val_all,
    output logic [NUM_SM-1:0]                set_req,
    output logic [NUM_SM-1:0]                clr_req,
    output logic [NUM_SM-1:0]                stg_we,
    output logic                             mctrl_we,
    output logic [BUS_W-1:0]                 rd_data
);
    localparam int PG_W = (NUM_SM > 1) ? $clog2(NUM_SM) : 1;

    logic [PG_W-1:0]  page_q;
    logic [BUS_W-1:0] rd_word;
    logic             stg_addr;
    int               vidx;

    assign mctrl_we = wr_en && (addr == A_MCTRL);
    assign set_req  = mctrl_we ? wdata[0 +: NUM_SM]      : '0;
    assign clr_req  = mctrl_we ? wdata[NUM_SM +: NUM_SM] : '0;
    assign stg_addr = (addr != A_MCTRL) && (addr != A_PAGE);

    for (genvar i = 0; i < NUM_SM; i++) begin : g_we
        assign stg_we[i] = wr_en && stg_addr && (page_q == PG_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       page_q <= '0;
        else if (wr_en && addr == A_PAGE) page_q <= wdata[PG_W-1:0];
    end

    assign vidx = (int'(page_q) * NUM_VAL + (int'(addr) - int'(A_VAL0))) * DATA_W;

    always_comb begin
        rd_word = '0;
        unique case (addr)
            A_MCTRL: begin
                rd_word[0 +: NUM_SM]          = ldok;
                rd_word[2*NUM_SM +: NUM_SM]   = run_q;
                rd_word[3*NUM_SM +: NUM_SM]   = ipol_buf;
            end
            A_PAGE:  rd_word[PG_W-1:0]   = page_q;
            A_PRSC:  rd_word[PRSC_W-1:0] = stg_prsc_all[int'(page_q)*PRSC_W +: PRSC_W];
            A_INIT:  rd_word[DATA_W-1:0] = stg_init_all[int'(page_q)*DATA_W +: DATA_W];
            A_MODE:  rd_word[0]          = mode_all[page_q];
            A_FRAC:  rd_word[FRAC_W-1:0] = stg_frac_all[int'(page_q)*FRAC_W +: FRAC_W];
            default: begin
                if (int'(addr) >= int'(A_VAL0) && int'(addr) < int'(A_VAL0) + NUM_VAL)
                    rd_word[DATA_W-1:0] = stg_val_all[vidx +: DATA_W];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end

    assert_set_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mctrl_we && wdata[0 +: NUM_SM] == '0) |-> (set_req == '0));
endmodule

// File: rtl/pwm_master_ctl.sv
module pwm_master_ctl #(
    parameter int NUM_SM = 4,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mctrl_we,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [NUM_SM-1:0] force_evt,
    input  logic [NUM_SM-1:0] clk_sel_aux,
    output logic [NUM_SM-1:0] run_q,
    output logic [NUM_SM-1:0] ipol_buf,
    output logic [NUM_SM-1:0] pol_active,
    output logic [NUM_SM-1:0] gen_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= '0;
            ipol_buf <= '0;
        end else if (mctrl_we) begin
            run_q    <= wdata[2*NUM_SM +: NUM_SM];
            ipol_buf <= wdata[3*NUM_SM +: NUM_SM];
        end
    end

    for (genvar i = 0; i < NUM_SM; i++) begin : g_sm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pol_active[i] <= 1'b0;
            else if (force_evt[i]) pol_active[i] <= ipol_buf[i];
        end
        if (i == 0) begin : g_own
            assign gen_en[i] = run_q[i];
        end else begin : g_aux
            assign gen_en[i] = clk_sel_aux[i] ? run_q[0] : run_q[i];
        end
        assert_pol_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !force_evt[i] |=> $stable(pol_active[i]));
    end
endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import pwm_reload_pkg::*;
#(
    parameter int NUM_SM  = 4,
    parameter int BUS_W   = 16,
    parameter int DATA_W  = 16,
    parameter int PRSC_W  = 3,
    parameter int FRAC_W  = 5,
    parameter int NUM_VAL = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [3:0]                       addr,
    input  logic [BUS_W-1:0]                 wdata,
    output logic [BUS_W-1:0]                 rd_data,
    input  logic [NUM_SM-1:0]                reload_evt,
    input  logic [NUM_SM-1:0]                force_evt,
    input  logic [NUM_SM-1:0]                clk_sel_aux,
    output logic [NUM_SM-1:0]                commit_pulse,
    output logic [NUM_SM-1:0]                gen_en,
    output logic [NUM_SM-1:0]                pol_active,
    output logic [NUM_SM*PRSC_W-1:0]         act_prsc,
    output logic [NUM_SM*DATA_W-1:0]         act_init,
    output logic [NUM_SM*FRAC_W-1:0]         act_frac,
    output logic [NUM_SM*NUM_VAL*DATA_W-1:0] act_val
);
    localparam int VSET_W = NUM_VAL * DATA_W;

    logic [NUM_SM-1:0]        set_req, clr_req, stg_we, ldok, mode_all, run_q, ipol_buf;
    logic                     mctrl_we;
    logic [NUM_SM*PRSC_W-1:0] stg_prsc_all;
    logic [NUM_SM*DATA_W-1:0] stg_init_all;
    logic [NUM_SM*FRAC_W-1:0] stg_frac_all;
    logic [NUM_SM*VSET_W-1:0] stg_val_all;

    pwm_bus_decode #(
        .NUM_SM(NUM_SM), .BUS_W(BUS_W), .DATA_W(DATA_W),
        .PRSC_W(PRSC_W), .FRAC_W(FRAC_W), .NUM_VAL(NUM_VAL)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .ldok(ldok), .run_q(run_q), .ipol_buf(ipol_buf), .mode_all(mode_all),
        .stg_prsc_all(stg_prsc_all), .stg_init_all(stg_init_all),
        .stg_frac_all(stg_frac_all), .stg_val_all(stg_val_all),
        .set_req(set_req), .clr_req(clr_req), .stg_we(stg_we),
        .mctrl_we(mctrl_we), .rd_data(rd_data)
    );

    pwm_master_ctl #(.NUM_SM(NUM_SM), .BUS_W(BUS_W)) u_mst (
        .clk(clk), .rst_n(rst_n), .mctrl_we(mctrl_we), .wdata(wdata),
        .force_evt(force_evt), .clk_sel_aux(clk_sel_aux),
        .run_q(run_q), .ipol_buf(ipol_buf), .pol_active(pol_active), .gen_en(gen_en)
    );

    for (genvar i = 0; i < NUM_SM; i++) begin : g_ld
        pwm_sm_loader #(
            .BUS_W(BUS_W), .DATA_W(DATA_W), .PRSC_W(PRSC_W),
            .FRAC_W(FRAC_W), .NUM_VAL(NUM_VAL)
        ) u_ld (
            .clk(clk), .rst_n(rst_n),
            .set_req(set_req[i]), .clr_req(clr_req[i]), .stg_we(stg_we[i]),
            .addr(addr), .wdata(wdata), .reload_evt(reload_evt[i]),
            .ldok(ldok[i]), .commit(commit_pulse[i]), .mode_q(mode_all[i]),
            .stg_prsc(stg_prsc_all[i*PRSC_W +: PRSC_W]),
            .stg_init(stg_init_all[i*DATA_W +: DATA_W]),
            .stg_frac(stg_frac_all[i*FRAC_W +: FRAC_W]),
            .stg_val(stg_val_all[i*VSET_W +: VSET_W]),
            .act_prsc(act_prsc[i*PRSC_W +: PRSC_W]),
            .act_init(act_init[i*DATA_W +: DATA_W]),
            .act_frac(act_frac[i*FRAC_W +: FRAC_W]),
            .act_val(act_val[i*VSET_W +: VSET_W])
        );

        assert_no_cross_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!ldok[i]) |-> !commit_pulse[i]);
    end
endmodule

// File: tb/tb_pwm_reload_ctrl.sv
module tb_pwm_reload_ctrl;
    localparam int NS = 4, BW = 16, DW = 16, PW = 3, FW = 5, NV = 2;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [BW-1:0] wdata = '0, rd_data;
    logic [NS-1:0] reload_evt = '0, force_evt = '0, clk_sel_aux = '0;
    logic [NS-1:0] commit_pulse, gen_en, pol_active;
    logic [NS*PW-1:0] act_prsc;
    logic [NS*DW-1:0] act_init;
    logic [NS*FW-1:0] act_frac;
    logic [NS*NV*DW-1:0] act_val;

    pwm_reload_ctrl #(.NUM_SM(NS), .BUS_W(BW), .DATA_W(DW), .PRSC_W(PW), .FRAC_W(FW), .NUM_VAL(NV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .reload_evt(reload_evt), .force_evt(force_evt),
        .clk_sel_aux(clk_sel_aux), .commit_pulse(commit_pulse), .gen_en(gen_en),
        .pol_active(pol_active), .act_prsc(act_prsc), .act_init(act_init),
        .act_frac(act_frac), .act_val(act_val)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    logic [NS-1:0] m_ldok = '0, m_mode = '0, m_run = '0, m_ipol = '0, m_pol = '0;
    logic [1:0]    m_page = '0;
    logic [PW-1:0] s_prsc [NS], a_prsc [NS];
    logic [DW-1:0] s_init [NS], a_init [NS];
    logic [FW-1:0] s_frac [NS], a_frac [NS];
    logic [DW-1:0] s_val [NS][NV], a_val [NS][NV];
    logic [BW-1:0] exp_rd;
    logic          rd_pend;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_commit(int i);
        logic clr = wr_en && addr == 4'd0 && wdata[NS+i];
        return m_ldok[i] && !clr && (m_mode[i] || reload_evt[i]);
    endfunction

    function automatic logic [BW-1:0] model_rd();
        logic [BW-1:0] r = '0;
        case (addr)
            4'd0: r = {m_ipol, m_run, 4'b0000, m_ldok};
            4'd1: r = BW'(m_page);
            4'd2: r = BW'(s_prsc[m_page]);
            4'd3: r = s_init[m_page];
            4'd4: r = BW'(m_mode[m_page]);
            4'd5: r = BW'(s_frac[m_page]);
            4'd6: r = s_val[m_page][0];
            4'd7: r = s_val[m_page][1];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_step();
        logic [NS-1:0] c;
        for (int i = 0; i < NS; i++) c[i] = exp_commit(i);
        for (int i = 0; i < NS; i++) begin
            if (c[i]) begin
                a_prsc[i] = s_prsc[i]; a_init[i] = s_init[i]; a_frac[i] = s_frac[i];
                for (int v = 0; v < NV; v++) a_val[i][v] = s_val[i][v];
            end
            if (force_evt[i]) m_pol[i] = m_ipol[i];
        end
        if (wr_en) begin
            if (addr == 4'd0) begin
                for (int i = 0; i < NS; i++) begin
                    if (wdata[NS+i])   m_ldok[i] = 1'b0;
                    else if (c[i])     m_ldok[i] = 1'b0;
                    else if (wdata[i]) m_ldok[i] = 1'b1;
                end
                m_run  = wdata[2*NS +: NS];
                m_ipol = wdata[3*NS +: NS];
            end else begin
                for (int i = 0; i < NS; i++) if (c[i]) m_ldok[i] = 1'b0;
                if (addr == 4'd1) m_page = wdata[1:0];
                else if (addr == 4'd4) m_mode[m_page] = wdata[0];
                else if (!m_ldok[m_page] && !c[m_page]) begin
                    case (addr)
                        4'd2: s_prsc[m_page] = wdata[PW-1:0];
                        4'd3: s_init[m_page] = wdata;
                        4'd5: s_frac[m_page] = wdata[FW-1:0];
                        4'd6: s_val[m_page][0] = wdata;
                        4'd7: s_val[m_page][1] = wdata;
                        default: ;
                    endcase
                end
            end
        end else begin
            for (int i = 0; i < NS; i++) if (c[i]) m_ldok[i] = 1'b0;
        end
    endtask

    task automatic cmp_all();
        for (int i = 0; i < NS; i++) begin
            chk("R5 act_init", act_init[i*DW +: DW], a_init[i]);
            chk("R5 act_prsc", act_prsc[i*PW +: PW], a_prsc[i]);
            chk("R5 act_frac", act_frac[i*FW +: FW], a_frac[i]);
            for (int v = 0; v < NV; v++)
                chk("R5 act_val", act_val[(i*NV+v)*DW +: DW], a_val[i][v]);
            chk("R11 pol_active", pol_active[i], m_pol[i]);
            chk(i == 0 ? "R9 gen_en" : "R10 gen_en", gen_en[i],
                (i != 0 && clk_sel_aux[i]) ? m_run[0] : m_run[i]);
        end
    endtask

    // one cycle, entered and left at a falling edge
    task automatic cyc(input logic w, input logic r, input logic [3:0] a, input logic [BW-1:0] d,
                       input logic [NS-1:0] rl, input logic [NS-1:0] fo);
        wr_en = w; rd_en = r; addr = a; wdata = d; reload_evt = rl; force_evt = fo;
        #1;
        for (int i = 0; i < NS; i++) chk("R8 commit_pulse", commit_pulse[i], exp_commit(i));
        rd_pend = r;
        if (r) exp_rd = model_rd();
        model_step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; rd_en = 0; reload_evt = '0; force_evt = '0;
        cmp_all();
        if (rd_pend) chk("R2 rd_data", rd_data, exp_rd);
    endtask

    task automatic wr(input logic [3:0] a, input logic [BW-1:0] d);
        cyc(1'b1, 1'b0, a, d, '0, '0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [BW-1:0] d);
        cyc(1'b0, 1'b1, a, '0, '0, '0);
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [BW-1:0] d;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NS; i++) begin
            s_prsc[i] = '0; a_prsc[i] = '0; s_init[i] = '0; a_init[i] = '0;
            s_frac[i] = '0; a_frac[i] = '0;
            for (int v = 0; v < NV; v++) begin s_val[i][v] = '0; a_val[i][v] = '0; end
        end
        repeat (3) @(negedge clk);
        chk("R1 act_init reset", act_init, '0);
        chk("R1 gen_en reset", gen_en, '0);
        chk("R1 pol_active reset", pol_active, '0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all();
        rd(4'd0, d); chk("R1 master read", d, 16'h0000);

        // stage submodule 1, mode 0
        wr(4'd1, 16'd1);
        wr(4'd2, 16'd5); wr(4'd3, 16'h1234); wr(4'd5, 16'd9);
        wr(4'd6, 16'hAAAA); wr(4'd7, 16'h5555);
        wr(4'd0, 16'h0002);
        rd(4'd0, d); chk("R2 set load-okay", d, 16'h0002);
        wr(4'd0, 16'h0000);
        rd(4'd0, d); chk("R2 write 0 keeps load-okay", d, 16'h0002);
        wr(4'd3, 16'hFFFF);
        rd(4'd3, d); chk("R7 locked staged init", d, 16'h1234);
        cyc(1'b0, 1'b0, 4'd0, '0, 4'b0100, '0);
        chk("R12 other reload no commit", act_init[DW +: DW], 16'h0000);
        cyc(1'b0, 1'b0, 4'd0, '0, 4'b0010, '0);
        chk("R5 commit on reload", act_init[DW +: DW], 16'h1234);
        chk("R5 commit val1", act_val[(1*NV+1)*DW +: DW], 16'h5555);
        rd(4'd0, d); chk("R8 load-okay self-cleared", d, 16'h0000);

        // clear strobe vs reload
        wr(4'd3, 16'h4321);
        wr(4'd0, 16'h0002);
        cyc(1'b1, 1'b0, 4'd0, 16'h0020, 4'b0010, '0);
        chk("R4 cancelled transfer", act_init[DW +: DW], 16'h1234);
        rd(4'd0, d); chk("R4 load-okay cleared", d, 16'h0000);
        wr(4'd0, 16'h0001);
        wr(4'd0, 16'h00F0);
        rd(4'd0, d); chk("R3 strobe clears and reads 0", d, 16'h0000);

        // immediate mode on submodule 3
        wr(4'd1, 16'd3); wr(4'd4, 16'd1); wr(4'd3, 16'h0BEE);
        wr(4'd0, 16'h0008);
        cyc(1'b0, 1'b0, 4'd0, '0, '0, '0);
        chk("R6 immediate commit", act_init[3*DW +: DW], 16'h0BEE);
        rd(4'd0, d); chk("R6 load-okay cleared", d, 16'h0000);

        // run and aux clock
        wr(4'd0, 16'h0100);
        chk("R9 run drives gen_en", gen_en, 4'b0001);
        clk_sel_aux = 4'b0100;
        #1 chk("R10 aux follows run0", gen_en, 4'b0101);
        wr(4'd0, 16'h0400);
        chk("R10 local run ignored", gen_en, 4'b0000);
        clk_sel_aux = '0;

        // polarity buffer
        wr(4'd0, 16'h4000);
        rd(4'd0, d); chk("R11 buffered read", d, 16'h4000);
        chk("R11 not active before force", pol_active, 4'b0000);
        cyc(1'b0, 1'b0, 4'd0, '0, '0, 4'b0100);
        chk("R11 active after force", pol_active, 4'b0100);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic w, r;
            logic [3:0] a;
            logic [BW-1:0] dd;
            logic [NS-1:0] rl, fo;
            w  = ($urandom_range(0, 99) < 35);
            r  = ($urandom_range(0, 99) < 20);
            a  = 4'($urandom_range(0, 7));
            dd = 16'($urandom());
            if (a == 4'd0 && $urandom_range(0, 99) >= 15) dd[7:4] = 4'b0000;
            if (a == 4'd0 && $urandom_range(0, 99) < 50) dd[3:0] = 4'b0000;
            if (a == 4'd4 && $urandom_range(0, 99) < 60) dd[0] = 1'b0;
            for (int i = 0; i < NS; i++) begin
                rl[i] = ($urandom_range(0, 99) < 15);
                fo[i] = ($urandom_range(0, 99) < 10);
            end
            if ($urandom_range(0, 99) < 5) clk_sel_aux = 4'($urandom());
            cyc(w, r, a, dd, rl, fo);
        end
        finish_run();
    end
endmodule